// File: doc/BRIEF.md
# CAN Bit Timing Unit

This block turns a stream of time-quantum ticks into CAN bit framing. Each nominal bit is made of three segments: a single-quantum synchronization segment, a first segment whose last quantum is the sample point, and a second segment whose end is the transmit point where the next bit begins. The block samples the received bus level at the sample point. It emits one pulse at each sample point and one pulse at the start of every bit, which is where a transmitter would launch its next bit.

Nodes drift against each other, so the block follows the bus. When the bus is idle and a hard-sync request is raised, a dominant edge restarts the bit on the spot. Otherwise a dominant edge that comes late stretches the first segment, and one that comes early trims the second segment. The amount of any correction is capped by a programmable jump width, and at most one correction is made per bit. A separate flag reports configurations whose total bit length is too short to be usable. The quantum tick comes from an external prescaler. Frame decoding and stuffing belong to the logic that consumes the sampled bits.

Top module: `can_bit_timer`

## Requirements
- R1: While reset is held, and afterwards until the first tick, `sample_pulse` and `bit_start` are 0 and `rx_bit` is 1. The first tick after reset is a synchronization quantum, so it produces a `bit_start` pulse.
- R2: Every quantum `q` is counted from the latest synchronization quantum, which is `q=0`. A `bit_start` pulse marks each synchronization quantum. With no edges on the bus, the next bit starts at `q = 1 + (bs1_m1+1) + (bs2_m1+1)`.
- R3: The first segment lasts `bs1_m1+1` quanta, from 1 to 16. The bus is sampled in its last quantum: `sample_pulse` pulses and `rx_bit` takes the `rx_in` value of that tick. At no other time does `rx_bit` change. A sample pulse and a start pulse never occur together.
- R4: The second segment lasts `bs2_m1+1` quanta, from 1 to 8. When it ends, the next bit begins.
- R5: A recessive-to-dominant edge (`rx_in` going from 1 to 0 between ticks) seen at quantum `q` inside the first segment lengthens that segment by `min(q, rjw_m1+1)` quanta. The jump width `rjw_m1+1` ranges from 1 to 4.
- R6: A recessive-to-dominant edge inside the second segment is an early edge. If the quanta left until the nominal next bit start are no more than the jump width, that quantum becomes the synchronization quantum of a new bit. Otherwise the second segment is shortened by the jump width.
- R7: Only one resynchronization is made per bit. Later edges in the same bit, edges in the synchronization quantum, and dominant-to-recessive edges have no effect on timing.
- R8: When `hsync_req` is 1 on a tick that carries a recessive-to-dominant edge, that quantum becomes the synchronization quantum (`bit_start` pulse, no sample), whatever segment was running.
- R9: `cfg_bad` is 1 exactly when `3 + bs1_m1 + bs2_m1 < 5`, that is, when the bit is shorter than 5 quanta.
- R10: In cycles without `tq_en`, the timing does not advance and neither pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tq_en | input | 1 | Time-quantum tick, one clock wide |
| rx_in | input | 1 | Received bus level (1 = recessive) |
| hsync_req | input | 1 | Allow a hard synchronization on this tick's edge |
| bs1_m1 | input | 4 | First segment length minus one |
| bs2_m1 | input | 3 | Second segment length minus one |
| rjw_m1 | input | 2 | Jump width minus one |
| rx_bit | output | 1 | Bus value taken at the latest sample point |
| sample_pulse | output | 1 | One-clock pulse after a sample-point tick |
| bit_start | output | 1 | One-clock pulse after a synchronization-quantum tick |
| cfg_bad | output | 1 | Configured bit shorter than 5 quanta |

## Verification
Two functions can land on the same quantum. One case is a hard-sync edge on the sample-point quantum, which must restart the bit and suppress the sample. The other is a resynchronization edge on the last first-segment quantum, which must stretch the segment instead of sampling. Directed patterns place a dominant edge at exactly those quanta after a known hard sync. They are judged by the tick index of the next start pulse and by whether the sample count grew. Random bus toggling with sporadic hard-sync requests reaches further coincidences, and a bench model counting quanta from the last sync checks every tick.

// File: rtl/can_bt_pkg.sv
// Shared types for the CAN bit timing unit.
package can_bt_pkg;
    // Segment currently being executed within a nominal bit.
    typedef enum logic [1:0] {
        SEG_SYNC = 2'd0,
        SEG_ONE  = 2'd1,
        SEG_TWO  = 2'd2
    } seg_t;
endpackage

// File: rtl/cbt_edge_det.sv
// Recessive-to-dominant edge detector sampled on quantum ticks.
// Assumes rx_in is already synchronized to clk. The previous level is
// only refreshed on ticks, so an edge is judged quantum to quantum.
module cbt_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic tq_en,
    input  logic rx_in,
    output logic fall
);
    logic prev_q;

    // Remember the bus level seen at the previous tick (idle is recessive).
    always_ff @(posedge clk) begin
        if (!rst_n)
            prev_q <= 1'b1;
        else if (tq_en)
            prev_q <= rx_in;
    end

    // Falling edge on this tick: recessive last quantum, dominant now.
    always_comb fall = tq_en & prev_q & ~rx_in;
endmodule

// File: rtl/cbt_cfg_check.sv
// Configuration sanity check: flags bits shorter than the minimum length.
// Assumes lengths are encoded as value minus one.
module cbt_cfg_check #(
    parameter int BS1_W   = 4,
    parameter int BS2_W   = 3,
    parameter int MIN_TQ  = 5
) (
    input  logic [BS1_W-1:0] bs1_m1,
    input  logic [BS2_W-1:0] bs2_m1,
    output logic             cfg_bad
);
    localparam int SUM_W = ((BS1_W > BS2_W) ? BS1_W : BS2_W) + 2;

    logic [SUM_W-1:0] total;

    // Total bit length: one sync quantum plus both segments.
    always_comb begin
        total   = SUM_W'(bs1_m1) + SUM_W'(bs2_m1) + SUM_W'(3);
        cfg_bad = (total < SUM_W'(MIN_TQ));
    end
endmodule

// File: rtl/cbt_seq.sv
// Bit segment sequencer: walks sync, first and second segments one
// quantum per tick and applies hard sync and bounded resynchronization.
// Assumes the configuration is stable while bits are being timed.
module cbt_seq
    import can_bt_pkg::*;
#(
    parameter int BS1_W = 4,
    parameter int BS2_W = 3,
    parameter int RJW_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tq_en,
    input  logic             fall,
    input  logic             rx_in,
    input  logic             hsync_req,
    input  logic [BS1_W-1:0] bs1_m1,
    input  logic [BS2_W-1:0] bs2_m1,
    input  logic [RJW_W-1:0] rjw_m1,
    output logic             rx_bit,
    output logic             sample_pulse,
    output logic             bit_start
);
    localparam int MAX_SW = (BS1_W > BS2_W) ? BS1_W : BS2_W;
    localparam int CNT_W  = ((MAX_SW > RJW_W) ? MAX_SW : RJW_W) + 2;

    seg_t             seg_q, seg_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] ext_q, ext_d;
    logic [CNT_W-1:0] shr_q, shr_d;
    logic             done_q, done_d;
    logic             start_d, samp_d, rxbit_d;
    logic [CNT_W-1:0] len1, len2, rjw, perr, rem;
    logic             go;

    // Decoded segment lengths and jump width.
    always_comb begin
        len1 = CNT_W'(bs1_m1) + CNT_W'(1);
        len2 = CNT_W'(bs2_m1) + CNT_W'(1);
        rjw  = CNT_W'(rjw_m1) + CNT_W'(1);
        perr = cnt_q + CNT_W'(1);
        rem  = len2 - cnt_q;
    end

    // Next-quantum decision for the running segment.
    always_comb begin
        seg_d   = seg_q;
        cnt_d   = cnt_q;
        ext_d   = ext_q;
        shr_d   = shr_q;
        done_d  = done_q;
        samp_d  = 1'b0;
        rxbit_d = rx_bit;
        go      = 1'b0;
        if (tq_en) begin
            if (hsync_req && fall) begin
                go = 1'b1;
            end else begin
                case (seg_q)
                    SEG_SYNC: go = 1'b1;
                    SEG_ONE: begin
                        if (fall && !done_q) begin
                            ext_d  = (perr < rjw) ? perr : rjw;
                            done_d = 1'b1;
                        end
                        if (perr == len1 + ext_d) begin
                            samp_d  = 1'b1;
                            rxbit_d = rx_in;
                            seg_d   = SEG_TWO;
                            cnt_d   = '0;
                        end else begin
                            cnt_d = perr;
                        end
                    end
                    SEG_TWO: begin
                        if (fall && !done_q && rem <= rjw) begin
                            go = 1'b1;
                        end else begin
                            if (fall && !done_q) begin
                                shr_d  = rjw;
                                done_d = 1'b1;
                            end
                            if (perr == len2 - shr_d) begin
                                seg_d = SEG_SYNC;
                                cnt_d = '0;
                            end else begin
                                cnt_d = perr;
                            end
                        end
                    end
                    default: seg_d = SEG_SYNC;
                endcase
            end
        end
        if (go) begin
            seg_d  = SEG_ONE;
            cnt_d  = '0;
            ext_d  = '0;
            shr_d  = '0;
            done_d = 1'b0;
        end
        start_d = go;
    end

    // Register the segment state and the output pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seg_q        <= SEG_SYNC;
            cnt_q        <= '0;
            ext_q        <= '0;
            shr_q        <= '0;
            done_q       <= 1'b0;
            rx_bit       <= 1'b1;
            sample_pulse <= 1'b0;
            bit_start    <= 1'b0;
        end else begin
            seg_q        <= seg_d;
            cnt_q        <= cnt_d;
            ext_q        <= ext_d;
            shr_q        <= shr_d;
            done_q       <= done_d;
            rx_bit       <= rxbit_d;
            sample_pulse <= samp_d;
            bit_start    <= start_d;
        end
    end
endmodule

// File: rtl/can_bit_timer.sv
// CAN bit timing unit top: edge detection, segment sequencing and
// configuration check. Assumes one-clock quantum ticks from a prescaler
// and a synchronized bus input.
module can_bit_timer #(
    parameter int BS1_W = 4,
    parameter int BS2_W = 3,
    parameter int RJW_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tq_en,
    input  logic             rx_in,
    input  logic             hsync_req,
    input  logic [BS1_W-1:0] bs1_m1,
    input  logic [BS2_W-1:0] bs2_m1,
    input  logic [RJW_W-1:0] rjw_m1,
    output logic             rx_bit,
    output logic             sample_pulse,
    output logic             bit_start,
    output logic             cfg_bad
);
    logic fall;

    cbt_edge_det u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .tq_en (tq_en),
        .rx_in (rx_in),
        .fall  (fall)
    );

    cbt_seq #(.BS1_W(BS1_W), .BS2_W(BS2_W), .RJW_W(RJW_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .tq_en        (tq_en),
        .fall         (fall),
        .rx_in        (rx_in),
        .hsync_req    (hsync_req),
        .bs1_m1       (bs1_m1),
        .bs2_m1       (bs2_m1),
        .rjw_m1       (rjw_m1),
        .rx_bit       (rx_bit),
        .sample_pulse (sample_pulse),
        .bit_start    (bit_start)
    );

    cbt_cfg_check #(.BS1_W(BS1_W), .BS2_W(BS2_W), .MIN_TQ(5)) u_cfg (
        .bs1_m1  (bs1_m1),
        .bs2_m1  (bs2_m1),
        .cfg_bad (cfg_bad)
    );
endmodule

// File: rtl/can_bit_timer_chk.sv
// Port-level checker for the CAN bit timing unit, bound to the top.
// Keeps its own copy of the last ticked bus level to recognise edges.
module can_bit_timer_chk (
    input logic clk,
    input logic rst_n,
    input logic tq_en,
    input logic rx_in,
    input logic hsync_req,
    input logic rx_bit,
    input logic sample_pulse,
    input logic bit_start
);
    logic last_rx;

    // Bus level seen at the previous tick, as observed from outside.
    always_ff @(posedge clk) begin
        if (!rst_n)
            last_rx <= 1'b1;
        else if (tq_en)
            last_rx <= rx_in;
    end

    // R10: pulses only follow a tick.
    p_pulse_after_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_pulse || bit_start) |-> $past(tq_en));

    // R3: sample point and bit start never coincide.
    p_no_overlap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(sample_pulse && bit_start));

    // R3: sampled value only moves at a sample point.
    p_bit_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_pulse |-> $stable(rx_bit));

    // R3: sampled value is the bus level of the sample tick.
    p_bit_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sample_pulse |-> (rx_bit == $past(rx_in)));

    // R8: a hard-sync edge restarts the bit.
    p_hard_sync_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tq_en && hsync_req && last_rx && !rx_in) |=> bit_start);
endmodule

bind can_bit_timer can_bit_timer_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tq_en        (tq_en),
    .rx_in        (rx_in),
    .hsync_req    (hsync_req),
    .rx_bit       (rx_bit),
    .sample_pulse (sample_pulse),
    .bit_start    (bit_start)
);

// File: tb/can_bit_timer_test.sv
`timescale 1ns/1ps
module can_bit_timer_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tq_en = 1'b0;
    logic       rx_in = 1'b1;
    logic       hsync_req = 1'b0;
    logic [3:0] bs1_m1 = 4'd3;
    logic [2:0] bs2_m1 = 3'd2;
    logic [1:0] rjw_m1 = 2'd1;
    logic       rx_bit, sample_pulse, bit_start, cfg_bad;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // Bench-side model state: quanta counted from the last sync quantum.
    int   m_q, m_ext, m_shr;
    bit   m_done, m_prev, m_rxbit;
    int   tk, last_start, last_sample, n_samp;

    can_bit_timer uut (
        .clk(clk), .rst_n(rst_n), .tq_en(tq_en), .rx_in(rx_in),
        .hsync_req(hsync_req), .bs1_m1(bs1_m1), .bs2_m1(bs2_m1),
        .rjw_m1(rjw_m1), .rx_bit(rx_bit), .sample_pulse(sample_pulse),
        .bit_start(bit_start), .cfg_bad(cfg_bad)
    );

    always #10 clk = ~clk;

    task automatic check(input string tag, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d (tick %0d)", tag, what, act, exp, tk);
        end
    endtask

    task automatic model_reset();
        m_q = 0; m_ext = 0; m_shr = 0; m_done = 0; m_prev = 1; m_rxbit = 1;
        tk = 0; last_start = -1; last_sample = -1; n_samp = 0;
    endtask

    // One quantum of the reference: returns expected start and sample flags.
    task automatic model_step(input bit r, input bit h, output bit es, output bit ep);
        int l1, l2, rj, tot, rem;
        bit fl;
        l1 = int'(bs1_m1) + 1; l2 = int'(bs2_m1) + 1; rj = int'(rjw_m1) + 1;
        fl = m_prev && !r;
        m_prev = r;
        es = 0; ep = 0;
        tot = 1 + l1 + m_ext + l2 - m_shr;
        if ((h && fl) || m_q == 0) begin
            es = 1;
        end else if (fl && !m_done && m_q > l1 + m_ext && (tot - m_q) <= rj) begin
            es = 1;
        end else begin
            if (fl && !m_done) begin
                m_done = 1;
                if (m_q <= l1 + m_ext) m_ext = (m_q < rj) ? m_q : rj;
                else begin
                    rem = tot - m_q;
                    m_shr = rj;
                end
            end
            tot = 1 + l1 + m_ext + l2 - m_shr;
            if (m_q == l1 + m_ext) begin
                ep = 1;
                m_rxbit = r;
            end
            m_q = m_q + 1;
            if (m_q == tot) m_q = 0;
        end
        if (es) begin
            m_q = 1; m_ext = 0; m_shr = 0; m_done = 0;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; tq_en = 0; hsync_req = 0; rx_in = 1;
        repeat (3) @(negedge clk);
        check("R1", sample_pulse, 0, "sample_pulse in reset");
        check("R1", bit_start, 0, "bit_start in reset");
        check("R1", rx_bit, 1, "rx_bit in reset");
        rst_n = 1;
        model_reset();
    endtask

    // Apply one tick, compare with the model, then optionally idle.
    task automatic tick(input bit r, input bit h, input int idle);
        bit es, ep;
        bit held;
        @(negedge clk);
        tq_en = 1; rx_in = r; hsync_req = h;
        model_step(r, h, es, ep);
        @(negedge clk);
        tq_en = 0; hsync_req = 0;
        tk++;
        check("R2", bit_start, es, "bit_start");
        check("R3", sample_pulse, ep, "sample_pulse");
        check("R3", rx_bit, m_rxbit, "rx_bit");
        if (bit_start) last_start = tk;
        if (sample_pulse) begin last_sample = tk; n_samp++; end
        held = rx_bit;
        for (int i = 0; i < idle; i++) begin
            @(negedge clk);
            check("R10", sample_pulse | bit_start, 0, "pulse without tick");
            check("R10", rx_bit, held, "rx_bit moved without tick");
        end
    endtask

    // Align: recessive tick, then a hard-sync edge; returns sync tick index.
    task automatic hard_align(output int t);
        tick(1, 0, 0);
        tick(0, 1, 0);
        t = tk;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int t, ns, sd;
        sd = $urandom(32'd2024);

        // R9: configuration length check.
        bs1_m1 = 0; bs2_m1 = 0; #1 check("R9", cfg_bad, 1, "cfg 1+1+1");
        bs1_m1 = 1; bs2_m1 = 0; #1 check("R9", cfg_bad, 1, "cfg 1+2+1");
        bs1_m1 = 1; bs2_m1 = 1; #1 check("R9", cfg_bad, 0, "cfg 1+2+2");
        bs1_m1 = 2; bs2_m1 = 0; #1 check("R9", cfg_bad, 0, "cfg 1+3+1");
        bs1_m1 = 15; bs2_m1 = 7; #1 check("R9", cfg_bad, 0, "cfg 1+16+8");

        // R1 / R2 / R4: nominal bit, len1 4, len2 3.
        bs1_m1 = 3; bs2_m1 = 2; rjw_m1 = 1;
        do_reset();
        tick(1, 0, 1);
        check("R1", last_start, 1, "first tick is sync");
        hard_align(t);
        for (int q = 1; q <= 8; q++) tick(0, 0, 0);
        check("R2", last_start - t, 8, "nominal bit length");
        check("R4", last_sample - t, 4, "sample at end of segment 1");

        // R4: short first segment, long second segment.
        bs1_m1 = 0; bs2_m1 = 7; rjw_m1 = 0;
        do_reset();
        hard_align(t);
        for (int q = 1; q <= 10; q++) tick(0, 0, 0);
        check("R4", last_start - t, 10, "segment 2 of 8 quanta");
        check("R4", last_sample - t, 1, "sample after 1 quantum");

        // R5: late edge at q3 with jump width 2; rise at q1 ignored.
        bs1_m1 = 3; bs2_m1 = 2; rjw_m1 = 1;
        do_reset();
        hard_align(t);
        for (int q = 1; q <= 10; q++) tick((q == 1 || q == 2) ? 1'b1 : 1'b0, 0, 0);
        check("R5", last_sample - t, 6, "segment 1 lengthened by 2");
        check("R5", last_start - t, 10, "bit lengthened by 2");

        // R6: early edge at q6, remaining 2 within width 2: new bit at once.
        do_reset();
        hard_align(t);
        for (int q = 1; q <= 6; q++) tick((q < 6) ? 1'b1 : 1'b0, 0, 0);
        check("R6", last_start - t, 6, "immediate restart");
        check("R6", last_sample - t, 4, "sample before early edge");

        // R6: early edge at q5, width 1: segment 2 shortened by one.
        rjw_m1 = 0;
        do_reset();
        hard_align(t);
        for (int q = 1; q <= 7; q++) tick((q < 5) ? 1'b1 : 1'b0, 0, 0);
        check("R6", last_start - t, 7, "segment 2 shortened by 1");

        // R7: second edge in same bit (q8, in segment 2) has no effect.
        rjw_m1 = 1;
        do_reset();
        hard_align(t);
        for (int q = 1; q <= 10; q++)
            tick((q == 1 || q == 7) ? 1'b1 : 1'b0, 0, 0);
        check("R7", last_start - t, 10, "second edge ignored");

        // R8: hard-sync edge on the sample-point quantum.
        do_reset();
        hard_align(t);
        ns = n_samp;
        for (int q = 1; q <= 4; q++) tick((q < 4) ? 1'b1 : 1'b0, (q == 4) ? 1'b1 : 1'b0, 0);
        check("R8", last_start - t, 4, "hard sync restarts bit");
        check("R8", n_samp, ns, "no sample on hard sync quantum");

        // R5: late edge on the last segment 1 quantum stretches instead of sampling.
        do_reset();
        hard_align(t);
        ns = n_samp;
        for (int q = 1; q <= 4; q++) tick((q < 4) ? 1'b1 : 1'b0, 0, 0);
        check("R5", n_samp, ns, "no sample at q4 after late edge");

        // Random phases against the model.
        for (int c = 0; c < 5; c++) begin
            bs1_m1 = 4'($urandom_range(1, 15));
            bs2_m1 = 3'($urandom_range(0, 7));
            rjw_m1 = 2'($urandom_range(0, 3));
            do_reset();
            for (int n = 0; n < 300; n++) begin
                bit r;
                r = ($urandom_range(0, 5) == 0) ? ~rx_in : rx_in;
                tick(r, ($urandom_range(0, 19) == 0) ? 1'b1 : 1'b0, $urandom_range(0, 1));
            end
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule